// File: doc/BRIEF.md
# Dual-Width Parallel Host Bus Interface

This block is the slave end of a microprocessor bus in front of a display controller. The host drives a chip select, a register select, read and write strobes and a word-width select, and shares an 8-bit bidirectional data bus with the block. A strobe counts only on its falling edge and only while chip select is low. When register select is low, a write loads an index register. When it is high, the write goes to the control register that the index points at, and the block also hands the byte to the command core as a one-cycle notification.

The bus width is chosen at run time by the width-select pin. When that pin is high, only the upper four data lines carry data. Each byte then takes two transfers, the first holding the upper nibble and the second the lower. One phase toggle, shared by reads and writes, records which half comes next. Every completed control write holds an active-low busy flag low for a fixed number of clock cycles. Any write strobe that arrives in that window is dropped and recorded in a sticky error flag.

Top module: `host_bus_if`

## Requirements
- R1: After reset low, busy_n is 1 and wr_err is 0. The index and every control register read back as 0, and the next 4-bit transfer is taken as an upper nibble.
- R2: A completed write with rs=0 loads the index with the low log2(NREGS) bits of the byte. A read with rs=0 returns the index, zero-extended to 8 bits.
- R3: A completed write with rs=1 stores the byte in the control register selected by the index. On the next cycles cmd_valid pulses once with cmd_idx equal to that index and cmd_data equal to that byte. A read with rs=1 returns that register.
- R4: Strobes act on their high-to-low transition, and only while cs_n is 0. A write strobe with cs_n high changes no register.
- R5: With ws=1 each write byte takes two strobes on data_io[7:4]: the first supplies bits 7:4 and the second bits 3:0. data_io[3:0] is ignored, and nothing is committed after the first strobe alone.
- R6: With ws=1 the first read strobe returns bits 7:4 of the register on data_io[7:4] and the second returns bits 3:0 there. data_io[3:0] reads as 0 in both.
- R7: Any change of ws returns the phase to the upper nibble, so a half-finished byte is discarded.
- R8: If rs differs between the first and the second nibble, the pending nibble is discarded and the new strobe is taken as a fresh upper nibble.
- R9: After each completed control-register write, busy_n is low for exactly BUSY_CYC clock cycles.
- R10: A write strobe seen while busy_n is low changes no register and no phase, and sets wr_err. wr_err stays set until reset.
- R11: The block drives data_io only while cs_n and rd_n are both 0, and leaves it high-impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 0 selects the index register, 1 selects the indexed control register |
| rd_n | input | 1 | Read strobe, acts on its falling edge |
| wr_n | input | 1 | Write strobe, acts on its falling edge |
| ws | input | 1 | Width select: 1 for a 4-bit bus on data_io[7:4], 0 for an 8-bit bus |
| data_io | inout | 8 | Bidirectional host data bus |
| busy_n | output | 1 | Low while a control write is being processed |
| wr_err | output | 1 | Sticky flag for a write dropped while busy |
| cmd_valid | output | 1 | One-cycle pulse for each committed control write |
| cmd_idx | output | log2(NREGS) | Index of the committed control write |
| cmd_data | output | 8 | Byte of the committed control write |

## Verification
The hardest state to reach from the ports is a half-assembled nibble pair that is then broken, either by a change of ws or by a change of rs before the second strobe. The bench builds these cases on purpose. It issues a single nibble and then toggles ws or changes rs, and it chooses the nibble values so that the wrong assembly order gives a visibly different index or register value. A write that lands inside the busy window is forced by issuing a second strobe straight after a control write, with busy_n confirmed low first. Random 4-bit and 8-bit transactions against a bench model then mix the two widths and the two register targets.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    typedef enum logic {
        HALF_HI = 1'b0,
        HALF_LO = 1'b1
    } half_e;

    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
    } edge_st;
endpackage

// File: rtl/hpi_strobe_edge.sv
module hpi_strobe_edge
    import hpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_fall,
    output logic rd_fall
);
    edge_st st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_n;
        st_d.rd_prev = rd_n;
        wr_fall      = st_q.wr_prev & ~wr_n & ~cs_n;
        rd_fall      = st_q.rd_prev & ~rd_n & ~cs_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wr_prev <= 1'b1;
            st_q.rd_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_WR_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fall |=> !wr_fall); // R4
    AST_RD_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fall |=> !rd_fall); // R4
endmodule

// File: rtl/hpi_assemble.sv
module hpi_assemble
    import hpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_fall,
    input  logic       rd_fall,
    input  logic       rs,
    input  logic       ws,
    input  logic       busy,
    input  logic [7:0] din,
    output logic       done,
    output logic [7:0] done_byte,
    output logic       done_rs,
    output logic       rd_go,
    output logic       rd_rs,
    output half_e      rd_half,
    output logic       err
);
    typedef struct packed {
        logic       ws;
        half_e      phase;
        logic       first_rs;
        logic [3:0] hi_nib;
        logic       done;
        logic [7:0] byte_v;
        logic       done_rs;
        logic       rd_go;
        logic       rd_rs;
        half_e      rd_half;
        logic       err;
    } asm_st;

    asm_st st_d, st_q;
    half_e cur_phase;
    half_e eff_phase;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.rd_go = 1'b0;
        st_d.ws    = ws;
        cur_phase  = (ws != st_q.ws) ? HALF_HI : st_q.phase;
        eff_phase  = (cur_phase == HALF_LO && rs == st_q.first_rs) ? HALF_LO : HALF_HI;
        st_d.phase = cur_phase;

        if (wr_fall) begin
            if (busy) begin
                st_d.err   = 1'b1;
                st_d.phase = st_q.phase;
            end else if (!ws) begin
                st_d.done    = 1'b1;
                st_d.byte_v  = din;
                st_d.done_rs = rs;
                st_d.phase   = HALF_HI;
            end else if (eff_phase == HALF_HI) begin
                st_d.hi_nib   = din[7:4];
                st_d.first_rs = rs;
                st_d.phase    = HALF_LO;
            end else begin
                st_d.done    = 1'b1;
                st_d.byte_v  = {st_q.hi_nib, din[7:4]};
                st_d.done_rs = rs;
                st_d.phase   = HALF_HI;
            end
        end else if (rd_fall) begin
            st_d.rd_go = 1'b1;
            st_d.rd_rs = rs;
            if (!ws) begin
                st_d.rd_half = HALF_HI;
                st_d.phase   = HALF_HI;
            end else begin
                st_d.rd_half = eff_phase;
                if (eff_phase == HALF_HI) begin
                    st_d.first_rs = rs;
                    st_d.phase    = HALF_LO;
                end else begin
                    st_d.phase = HALF_HI;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign done_byte = st_q.byte_v;
    assign done_rs   = st_q.done_rs;
    assign rd_go     = st_q.rd_go;
    assign rd_rs     = st_q.rd_rs;
    assign rd_half   = st_q.rd_half;
    assign err       = st_q.err;

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fall && busy) |=> (!st_q.done && st_q.err)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err); // R10
    AST_WS_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ws != st_q.ws) && !wr_fall && !rd_fall) |=> (st_q.phase == HALF_HI)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R5
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs #(
    parameter int NREGS    = 16,
    parameter int BUSY_CYC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     done,
    input  logic [7:0]               done_byte,
    input  logic                     done_rs,
    input  logic                     rd_go,
    input  logic                     rd_rs,
    output logic                     busy,
    output logic [7:0]               rd_byte,
    output logic                     cmd_valid,
    output logic [$clog2(NREGS)-1:0] cmd_idx,
    output logic [7:0]               cmd_data
);
    localparam int IDX_W = $clog2(NREGS);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [IDX_W-1:0]      idx;
        logic [NREGS-1:0][7:0] file;
        logic [CNT_W-1:0]      cnt;
        logic [7:0]            rd_byte;
        logic                  cmd_valid;
        logic [IDX_W-1:0]      cmd_idx;
        logic [7:0]            cmd_data;
    } reg_st;

    reg_st st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.cmd_valid = 1'b0;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (done) begin
            if (!done_rs) begin
                st_d.idx = done_byte[IDX_W-1:0];
            end else begin
                st_d.file[st_q.idx] = done_byte;
                st_d.cmd_valid      = 1'b1;
                st_d.cmd_idx        = st_q.idx;
                st_d.cmd_data       = done_byte;
                st_d.cnt            = CNT_W'(BUSY_CYC);
            end
        end
        if (rd_go) begin
            st_d.rd_byte = rd_rs ? st_q.file[st_q.idx] : 8'(st_q.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.cnt != '0);
    assign rd_byte   = st_q.rd_byte;
    assign cmd_valid = st_q.cmd_valid;
    assign cmd_idx   = st_q.cmd_idx;
    assign cmd_data  = st_q.cmd_data;

    AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cmd_valid |-> (st_q.cnt == CNT_W'(BUSY_CYC))); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(BUSY_CYC)); // R9
    AST_IDX_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(st_q.idx)); // R10
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
    import hpi_pkg::*;
#(
    parameter int NREGS    = 16,
    parameter int BUSY_CYC = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     rs,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic                     ws,
    inout  wire  [7:0]               data_io,
    output logic                     busy_n,
    output logic                     wr_err,
    output logic                     cmd_valid,
    output logic [$clog2(NREGS)-1:0] cmd_idx,
    output logic [7:0]               cmd_data
);
    logic       wr_fall, rd_fall;
    logic       done, done_rs, rd_go, rd_rs, busy;
    logic [7:0] done_byte, rd_byte, dout;
    half_e      rd_half;
    logic       oe;

    hpi_strobe_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .wr_fall (wr_fall),
        .rd_fall (rd_fall)
    );

    hpi_assemble i_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fall   (wr_fall),
        .rd_fall   (rd_fall),
        .rs        (rs),
        .ws        (ws),
        .busy      (busy),
        .din       (data_io),
        .done      (done),
        .done_byte (done_byte),
        .done_rs   (done_rs),
        .rd_go     (rd_go),
        .rd_rs     (rd_rs),
        .rd_half   (rd_half),
        .err       (wr_err)
    );

    hpi_regs #(
        .NREGS    (NREGS),
        .BUSY_CYC (BUSY_CYC)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_byte (done_byte),
        .done_rs   (done_rs),
        .rd_go     (rd_go),
        .rd_rs     (rd_rs),
        .busy      (busy),
        .rd_byte   (rd_byte),
        .cmd_valid (cmd_valid),
        .cmd_idx   (cmd_idx),
        .cmd_data  (cmd_data)
    );

    always_comb begin
        oe = ~cs_n & ~rd_n;
        if (ws) begin
            dout = (rd_half == HALF_HI) ? {rd_byte[7:4], 4'h0} : {rd_byte[3:0], 4'h0};
        end else begin
            dout = rd_byte;
        end
    end

    assign data_io = oe ? dout : 8'bz;
    assign busy_n  = ~busy;

    AST_CMD_NOT_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !busy_n); // R9
endmodule

// File: tb/test_host_bus_if.sv
module test_host_bus_if;
    localparam int NREGS    = 16;
    localparam int BUSY_CYC = 12;
    localparam int IDX_W    = $clog2(NREGS);

    logic clk = 1'b0;
    logic rst_n, cs_n, rs, rd_n, wr_n, ws;
    logic [7:0] drv;
    logic drv_en;
    wire  [7:0] data_io;
    logic busy_n, wr_err, cmd_valid;
    logic [IDX_W-1:0] cmd_idx;
    logic [7:0] cmd_data;

    int checks = 0;
    int fails  = 0;
    int cmd_cnt = 0;
    logic [IDX_W-1:0] last_idx;
    logic [7:0] last_data;
    logic [7:0] model_ctl [NREGS];
    logic [IDX_W-1:0] model_idx;
    logic [7:0] got;
    int seed_v;

    always #2 clk = ~clk;

    assign data_io = drv_en ? drv : 8'bz;

    host_bus_if #(.NREGS(NREGS), .BUSY_CYC(BUSY_CYC)) i_host_bus_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rd_n(rd_n), .wr_n(wr_n),
        .ws(ws), .data_io(data_io), .busy_n(busy_n), .wr_err(wr_err),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_data(cmd_data)
    );

    always @(posedge clk) begin
        if (cmd_valid) begin
            cmd_cnt   <= cmd_cnt + 1;
            last_idx  <= cmd_idx;
            last_data <= cmd_data;
        end
    end

    function automatic logic [IDX_W-1:0] exp_idx(input logic [7:0] b);
        return b[IDX_W-1:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic strobe_wr(input logic r, input logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; rs = r; drv = v; drv_en = 1'b1;
        @(negedge clk); wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; drv_en = 1'b0;
    endtask

    task automatic write_byte(input logic r, input logic [7:0] v);
        if (ws) begin
            strobe_wr(r, {v[7:4], 4'h5});
            strobe_wr(r, {v[3:0], 4'hA});
        end else begin
            strobe_wr(r, v);
        end
    endtask

    task automatic strobe_rd(input logic r, output logic [7:0] v);
        @(negedge clk); cs_n = 1'b0; rs = r;
        @(negedge clk); rd_n = 1'b0;
        repeat (4) @(negedge clk);
        v = data_io;
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic read_byte(input logic r, output logic [7:0] v);
        logic [7:0] a, b;
        if (ws) begin
            strobe_rd(r, a);
            strobe_rd(r, b);
            chk("R6 low lines zero", {a[3:0], b[3:0]}, 8'h00);
            v = {a[7:4], b[7:4]};
        end else begin
            strobe_rd(r, v);
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (busy_n) break;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int n;
        int c0;
        seed_v = $urandom(32'd1234);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ws = 1'b0; rs = 1'b0;
        drv = 8'h00; drv_en = 1'b0; rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy_n", busy_n, 1);
        chk("R1 wr_err", wr_err, 0);
        read_byte(0, got); chk("R1 index", got, 0);
        read_byte(1, got); chk("R1 ctl reg", got, 0);

        // R2 index write and read
        write_byte(0, 8'h37);
        read_byte(0, got); chk("R2 index", got, 8'(exp_idx(8'h37)));

        // R3 control write, cmd notification, readback
        c0 = cmd_cnt;
        write_byte(1, 8'h9C);
        @(negedge clk);
        chk("R3 cmd count", cmd_cnt, c0 + 1);
        chk("R3 cmd idx", last_idx, 7);
        chk("R3 cmd data", last_data, 8'h9C);
        wait_ready();
        read_byte(1, got); chk("R3 readback", got, 8'h9C);

        // R9 busy length
        write_byte(0, 8'h02);
        @(negedge clk); cs_n = 1'b0; rs = 1'b1; drv = 8'h11; drv_en = 1'b1;
        @(negedge clk); wr_n = 1'b0;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i == 2) wr_n = 1'b1;
            if (i == 4) begin cs_n = 1'b1; drv_en = 1'b0; end
            if (!busy_n) n++;
        end
        chk("R9 busy cycles", n, BUSY_CYC);

        // R10 write during busy is dropped
        strobe_wr(1, 8'h22);
        chk("R10 busy precondition", busy_n, 0);
        strobe_wr(0, 8'h05);
        wait_ready();
        chk("R10 err set", wr_err, 1);
        read_byte(0, got); chk("R10 index unchanged", got, 8'h02);
        read_byte(1, got); chk("R10 ctl kept", got, 8'h22);
        chk("R10 err sticky", wr_err, 1);

        // R4 strobe with cs_n high
        @(negedge clk); cs_n = 1'b1; rs = 1'b0; drv = 8'h0A; drv_en = 1'b1;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1;
        repeat (2) @(negedge clk); drv_en = 1'b0;
        read_byte(0, got); chk("R4 no write without cs", got, 8'h02);

        // R11 bus release (design holds 0x02 latched)
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; drv = 8'hA5; drv_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 released cs high", data_io, 8'hA5);
        cs_n = 1'b0; rd_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 released rd high", data_io, 8'hA5);
        cs_n = 1'b1; drv_en = 1'b0;

        // R5 4-bit write, high nibble first, D3..D0 ignored
        ws = 1'b1;
        @(negedge clk);
        write_byte(0, 8'h04);
        c0 = cmd_cnt;
        strobe_wr(1, 8'hE3);
        @(negedge clk);
        chk("R5 no commit after one nibble", cmd_cnt, c0);
        strobe_wr(1, 8'h7C);
        @(negedge clk);
        chk("R5 commit data", last_data, 8'hE7);
        chk("R5 commit idx", last_idx, 4);
        wait_ready();

        // R6 4-bit read
        read_byte(1, got); chk("R6 nibble read", got, 8'hE7);

        // R7 width change discards half byte
        strobe_wr(0, 8'h30);
        ws = 1'b0; repeat (2) @(negedge clk);
        ws = 1'b1; repeat (2) @(negedge clk);
        write_byte(0, 8'h09);
        read_byte(0, got); chk("R7 phase cleared", got, 8'h09);

        // R8 rs change between nibbles restarts
        strobe_wr(0, 8'h10);
        c0 = cmd_cnt;
        write_byte(1, 8'h5A);
        @(negedge clk);
        chk("R8 commit count", cmd_cnt, c0 + 1);
        chk("R8 data", last_data, 8'h5A);
        chk("R8 idx", last_idx, 9);
        wait_ready();
        read_byte(0, got); chk("R8 index kept", got, 8'h09);

        // random mix against model
        for (int k = 0; k < NREGS; k++) model_ctl[k] = 8'h00;
        do_reset();
        model_idx = '0;
        for (int it = 0; it < 60; it++) begin
            logic [7:0] v;
            int op;
            ws = 1'($urandom_range(0, 1));
            @(negedge clk);
            op = $urandom_range(0, 3);
            v  = 8'($urandom_range(0, 255));
            case (op)
                0: begin write_byte(0, v); model_idx = exp_idx(v); end
                1: begin
                    c0 = cmd_cnt;
                    write_byte(1, v); model_ctl[model_idx] = v;
                    @(negedge clk);
                    chk("R3 random cmd", last_data, v);
                    wait_ready();
                end
                2: begin read_byte(0, got); chk("R2 random index", got, 8'(model_idx)); end
                default: begin read_byte(1, got); chk("R3 random ctl", got, model_ctl[model_idx]); end
            endcase
        end
        chk("R10 no err in clean traffic", wr_err, 0);

        // R1 reset mid-nibble
        ws = 1'b1;
        write_byte(0, 8'h06);
        write_byte(1, 8'hC4);
        wait_ready();
        strobe_wr(0, 8'hB0);
        do_reset();
        chk("R1 busy after reset", busy_n, 1);
        write_byte(0, 8'h06);
        read_byte(0, got); chk("R1 phase cleared by reset", got, 8'h06);
        read_byte(1, got); chk("R1 ctl cleared by reset", got, 8'h00);

        summary();
    end
endmodule